// File: doc/BRIEF.md
# Equalizer Lock-Mode Controller

This block sequences an adaptive cable equalizer. It decides on each clock whether the adaptation loop may change its setting, when the loop is held frozen, and when a fresh acquisition must start. Every video line it watches whether the loop changed its setting. After a run of unchanged lines it declares the equalizer settled. A 2-bit mode selects how a settled equalizer behaves after that.

It has four policies. The first keeps adapting and loses the settled state on any later change. The second freezes and starts again only after a long loss of signal. The third freezes and starts again only when the host leaves that mode for the free-running mode and comes back. The fourth hands control to fixed manual settings. A free-running controller also restarts on a full toggle of the polarity line. A board can therefore get a freeze-until-reset behaviour, without any host, by looping the settled output back into the external freeze input. Signal-absent time is measured in millisecond ticks from outside.

Top module: `eq_lock_ctrl`

## Requirements
- R1: After reset, with mode 00 and freeze low, `locked` and `restart` are low, `adapt_en` is high and the line count is zero.
- R2: `locked` rises at the clock edge that samples the LOCK_LINES-th consecutive `line_stb` with no honoured `setting_chg`, and not on any earlier strobe.
- R3: In mode 00 (continuous update), `adapt_en` stays high while locked. A strobe with `setting_chg` while adapting clears `locked` and restarts the line count.
- R4: In modes 01 and 10, once `locked` is high, `adapt_en` is low and `setting_chg` is ignored. `locked` stays high whatever `sig_present` does, until a restart.
- R5: In mode 00, a full toggle of `inv_eff` (leaving its level at reset and coming back to it) produces a restart at the edge that samples the return. A single edge produces none.
- R6: In mode 10 (lock until reset), `inv_eff` toggles have no effect. Moving the mode from 10 to 00 and back to 10 restarts at the edge that samples the return to 10.
- R7: In mode 01 (lock until signal loss), once `sig_present` has been low for at least LOSS_MS+1 `ms_tick` pulses, its return produces a restart. A shorter absence has no effect.
- R8: While `freeze_in` is high, `adapt_en` is low and `setting_chg` is ignored. Strobes still count toward lock.
- R9: In mode 11 (manual length), `manual_sel` is high, `adapt_en` is low, and `locked` and the line count are held clear.
- R10: A restart is a one-cycle `restart` pulse. At the same edge it clears `locked` and the line count, and `adapt_en` is high again unless freeze or manual mode holds it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_stb | input | 1 | One-cycle pulse per video line |
| setting_chg | input | 1 | Adaptation changed its setting on this line (valid with line_stb) |
| sig_present | input | 1 | Input signal detected |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| freeze_in | input | 1 | External hold of the equalizer state |
| inv_eff | input | 1 | Effective polarity line (pin or override) |
| mode | input | 2 | 00 continuous, 01 lock until loss, 10 lock until reset, 11 manual |
| locked | output | 1 | Equalizer settled |
| adapt_en | output | 1 | Adaptation loop may change its setting |
| restart | output | 1 | One-cycle pulse starting a new acquisition |
| manual_sel | output | 1 | Equalizer uses the manual settings |

## Verification
The two functions that can meet in one cycle are the settling count and a restart. A restart must win over a strobe that would lock, and a setting change that arrives while the block is frozen must not unlock it. The bench drives a full polarity toggle while the external freeze holds a locked equalizer in mode 00. It expects the restart pulse together with `locked` low at that edge, with `adapt_en` still held low by the freeze. It then sends strobes that carry setting changes under the freeze and expects the block to settle again after exactly LOCK_LINES of them.

// File: rtl/eq_lock_pkg.sv
// Shared mode encoding for the equalizer lock-mode controller.
package eq_lock_pkg;
    typedef enum logic [1:0] {
        MODE_CONT      = 2'b00,
        MODE_HOLD_LOSS = 2'b01,
        MODE_HOLD_RST  = 2'b10,
        MODE_MANUAL    = 2'b11
    } eq_mode_e;
endpackage

// File: rtl/eq_line_settle.sv
// Counts consecutive video lines without a setting change and flags lock.
// Assumes chg_valid is already gated by the adaptation enable; clear wins.
module eq_line_settle #(
    parameter int LOCK_LINES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic line_stb,
    input  logic chg_valid,
    output logic locked
);
    localparam int CW = $clog2(LOCK_LINES + 1);
    localparam logic [CW-1:0] LIM    = CW'(LOCK_LINES);
    localparam logic [CW-1:0] LIM_M1 = CW'(LOCK_LINES - 1);

    logic [CW-1:0] cnt_q;

    // Advance the run length per line; a change or clear restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q  <= '0;
            locked <= 1'b0;
        end else if (line_stb) begin
            if (chg_valid) begin
                cnt_q  <= '0;
                locked <= 1'b0;
            end else if (cnt_q != LIM) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LIM_M1) begin
                    locked <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/eq_loss_timer.sv
// Measures signal absence in millisecond ticks; flags the return of a
// signal after an absence of at least LOSS_MS+1 ticks.
module eq_loss_timer #(
    parameter int LOSS_MS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_present,
    input  logic ms_tick,
    output logic back_after_loss
);
    localparam int LOSS_TICKS = LOSS_MS + 1;
    localparam int TW = $clog2(LOSS_TICKS + 1);
    localparam logic [TW-1:0] ARM_AT = TW'(LOSS_TICKS - 1);

    logic [TW-1:0] cnt_q;
    logic          armed_q;

    // Count ticks while absent; presence clears count and arm flag.
    always_ff @(posedge clk) begin
        if (!rst_n || sig_present) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (ms_tick && !armed_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == ARM_AT) begin
                armed_q <= 1'b1;
            end
        end
    end

    // Signal is back while the long-loss flag is still set.
    assign back_after_loss = sig_present && armed_q;
endmodule

// File: rtl/eq_inv_toggle.sv
// Detects a full toggle of the polarity line: away from the level held at
// reset and back again. Assumes that level is the resting level.
module eq_inv_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic inv_eff,
    output logic toggle
);
    logic base_q;
    logic away_q;

    // Remember the resting level and whether the line has left it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= inv_eff;
            away_q <= 1'b0;
        end else if (!away_q && (inv_eff != base_q)) begin
            away_q <= 1'b1;
        end else if (away_q && (inv_eff == base_q)) begin
            away_q <= 1'b0;
        end
    end

    // Return to the resting level completes the toggle.
    assign toggle = away_q && (inv_eff == base_q);
endmodule

// File: rtl/eq_lock_ctrl.sv
// Lock-mode controller for an adaptive equalizer. Chooses the restart source
// for the selected mode, gates adaptation, and drives the settled flag.
// Assumes line_stb, ms_tick and setting_chg are synchronous one-cycle pulses.
module eq_lock_ctrl
    import eq_lock_pkg::*;
#(
    parameter int LOCK_LINES = 100,
    parameter int LOSS_MS    = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_stb,
    input  logic       setting_chg,
    input  logic       sig_present,
    input  logic       ms_tick,
    input  logic       freeze_in,
    input  logic       inv_eff,
    input  logic [1:0] mode,
    output logic       locked,
    output logic       adapt_en,
    output logic       restart,
    output logic       manual_sel
);
    eq_mode_e mode_e;
    eq_mode_e mode_q;
    logic     leave_q;
    logic     inv_toggle;
    logic     loss_back;
    logic     restart_req;
    logic     frozen;
    logic     settle_clr;

    assign mode_e = eq_mode_e'(mode);

    // Track the previous mode and whether 10 was left for 00.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_CONT;
            leave_q <= 1'b0;
        end else begin
            mode_q <= mode_e;
            if (mode_q == MODE_HOLD_RST && mode_e == MODE_CONT) begin
                leave_q <= 1'b1;
            end else if (mode_e != MODE_CONT) begin
                leave_q <= 1'b0;
            end
        end
    end

    // Pick the restart source allowed by the current mode.
    always_comb begin
        unique case (mode_e)
            MODE_CONT:      restart_req = inv_toggle;
            MODE_HOLD_LOSS: restart_req = loss_back;
            MODE_HOLD_RST:  restart_req = leave_q;
            default:        restart_req = 1'b0;
        endcase
    end

    // Register the restart request into a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restart <= 1'b0;
        end else begin
            restart <= restart_req;
        end
    end

    assign manual_sel = (mode_e == MODE_MANUAL);
    assign frozen     = locked && (mode_e == MODE_HOLD_LOSS || mode_e == MODE_HOLD_RST);
    assign adapt_en   = !manual_sel && !freeze_in && !frozen;
    assign settle_clr = restart_req || manual_sel;

    eq_line_settle #(.LOCK_LINES(LOCK_LINES)) u_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (settle_clr),
        .line_stb  (line_stb),
        .chg_valid (setting_chg && adapt_en),
        .locked    (locked)
    );

    eq_loss_timer #(.LOSS_MS(LOSS_MS)) u_loss (
        .clk             (clk),
        .rst_n           (rst_n),
        .sig_present     (sig_present),
        .ms_tick         (ms_tick),
        .back_after_loss (loss_back)
    );

    eq_inv_toggle u_inv (
        .clk     (clk),
        .rst_n   (rst_n),
        .inv_eff (inv_eff),
        .toggle  (inv_toggle)
    );
endmodule

// File: rtl/eq_lock_ctrl_chk.sv
// Temporal checks on the lock-mode controller ports, bound to the top.
module eq_lock_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       line_stb,
    input logic       freeze_in,
    input logic [1:0] mode,
    input logic       locked,
    input logic       restart
);
    // R2
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(line_stb));

    // R4
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && mode == 2'b10 && !freeze_in) |=> (locked || restart));

    // R8
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_in && locked && mode != 2'b11) |=> (locked || restart));

    // R9
    manual_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |=> !locked);

    // R10
    restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !restart);

    // R10
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> !locked);
endmodule

bind eq_lock_ctrl eq_lock_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_stb  (line_stb),
    .freeze_in (freeze_in),
    .mode      (mode),
    .locked    (locked),
    .restart   (restart)
);

// File: tb/eq_lock_ctrl_test.sv
`timescale 1ns/100ps
module eq_lock_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_stb = 1'b0;
    logic       setting_chg = 1'b0;
    logic       sig_present = 1'b1;
    logic       ms_tick = 1'b0;
    logic       freeze_in = 1'b0;
    logic       inv_eff = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       locked, adapt_en, restart, manual_sel;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    eq_lock_ctrl uut (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .setting_chg(setting_chg),
        .sig_present(sig_present), .ms_tick(ms_tick), .freeze_in(freeze_in),
        .inv_eff(inv_eff), .mode(mode), .locked(locked), .adapt_en(adapt_en),
        .restart(restart), .manual_sel(manual_sel)
    );

    // Vector: {mode, freeze, lines, change on first line, exp locked, exp adapt}
    // Entries 0-1 cover R2, 2-4 cover R3, 5-6 cover R4.
    localparam int NV = 7;
    localparam logic [13:0] VEC [NV] = '{
        {2'b00, 1'b0, 8'd99,  1'b0, 1'b0, 1'b1},
        {2'b00, 1'b0, 8'd1,   1'b0, 1'b1, 1'b1},
        {2'b00, 1'b0, 8'd1,   1'b1, 1'b0, 1'b1},
        {2'b00, 1'b0, 8'd100, 1'b0, 1'b1, 1'b1},
        {2'b00, 1'b0, 8'd50,  1'b1, 1'b0, 1'b1},
        {2'b10, 1'b0, 8'd51,  1'b0, 1'b1, 1'b0},
        {2'b10, 1'b0, 8'd3,   1'b1, 1'b1, 1'b0}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic lines(input int n, input logic chg_first);
        for (int i = 0; i < n; i++) begin
            line_stb    = 1'b1;
            setting_chg = (i == 0) && chg_first;
            step();
        end
        line_stb    = 1'b0;
        setting_chg = 1'b0;
    endtask

    task automatic tick();
        ms_tick = 1'b1;
        step();
        ms_tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 locked after reset", locked, 1'b0);
        chk("R1 restart after reset", restart, 1'b0);
        chk("R1 adapt_en after reset", adapt_en, 1'b1);
        chk("R1 manual_sel after reset", manual_sel, 1'b0);

        // Table walk: R2 R3 R4
        for (int v = 0; v < NV; v++) begin
            mode      = VEC[v][13:12];
            freeze_in = VEC[v][11];
            lines(int'(VEC[v][10:3]), VEC[v][2]);
            chk($sformatf("R2 R3 R4 table %0d locked", v), locked, VEC[v][1]);
            chk($sformatf("R2 R3 R4 table %0d adapt_en", v), adapt_en, VEC[v][0]);
        end

        // R4: long absence in mode 10 leaves lock in place
        sig_present = 1'b0;
        repeat (5) tick();
        sig_present = 1'b1;
        step();
        chk("R4 no restart after loss in mode 10", restart, 1'b0);
        chk("R4 locked held through loss", locked, 1'b1);

        // R6: polarity toggle ignored in mode 10
        inv_eff = 1'b1; step();
        chk("R6 no restart on invert edge", restart, 1'b0);
        inv_eff = 1'b0; step();
        chk("R6 no restart on invert return", restart, 1'b0);
        chk("R6 locked after invert toggle", locked, 1'b1);

        // R6: mode round trip 10 -> 00 -> 10
        mode = 2'b00; step();
        chk("R6 no restart on leaving 10", restart, 1'b0);
        mode = 2'b10; step();
        chk("R6 restart on return to 10", restart, 1'b1);
        chk("R10 locked cleared by restart", locked, 1'b0);
        chk("R10 adapt_en after restart", adapt_en, 1'b1);
        step();
        chk("R10 restart lasts one cycle", restart, 1'b0);

        // R8 / R5: freeze wired style in mode 00
        mode = 2'b00;
        lines(100, 1'b0);
        chk("R2 locked after 100 lines in 00", locked, 1'b1);
        freeze_in = 1'b1; step();
        chk("R8 adapt_en low under freeze", adapt_en, 1'b0);
        lines(1, 1'b1);
        chk("R8 change ignored under freeze", locked, 1'b1);
        inv_eff = 1'b1; step();
        chk("R5 single invert edge no restart", restart, 1'b0);
        inv_eff = 1'b0; step();
        chk("R5 full toggle restarts", restart, 1'b1);
        chk("R5 locked cleared by toggle", locked, 1'b0);
        chk("R8 adapt_en still held by freeze", adapt_en, 1'b0);
        lines(99, 1'b1);
        chk("R8 not locked after 99 frozen lines", locked, 1'b0);
        lines(1, 1'b1);
        chk("R8 lines count under freeze", locked, 1'b1);
        freeze_in = 1'b0;

        // R7: mode 01 short and long absence
        mode = 2'b01; step();
        chk("R4 adapt_en low when locked in 01", adapt_en, 1'b0);
        sig_present = 1'b0;
        tick();
        sig_present = 1'b1; step();
        chk("R7 short loss no restart", restart, 1'b0);
        chk("R7 locked after short loss", locked, 1'b1);
        sig_present = 1'b0;
        tick(); tick();
        step();
        chk("R7 no restart while still absent", restart, 1'b0);
        sig_present = 1'b1; step();
        chk("R7 long loss restarts on return", restart, 1'b1);
        chk("R7 locked cleared", locked, 1'b0);
        chk("R7 adapt_en after restart", adapt_en, 1'b1);
        lines(100, 1'b0);
        chk("R4 relocks in 01", locked, 1'b1);

        // R9: manual mode
        mode = 2'b11; step();
        chk("R9 manual_sel", manual_sel, 1'b1);
        chk("R9 adapt_en low", adapt_en, 1'b0);
        chk("R9 locked cleared", locked, 1'b0);
        lines(120, 1'b0);
        chk("R9 no lock in manual", locked, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule